// File: doc/BRIEF.md
# Authentication Response Packet Checker

This block judges a fixed-length reply that an external security device returns when challenged. The reply arrives one byte per accepted transfer on a valid/ready byte stream. The block does not store the packet. It works on the bytes as they arrive:

- It recovers the masked part of the payload by XOR with a key carried in the packet itself.
- It keeps a running 8-bit sum of the recovered bytes.
- It tracks whether the opening bytes match a known counterfeit signature.

When the last byte is accepted, the block raises a done flag. At the same time it presents one of three verdicts: genuine, illegal or counterfeit. Verdict and flag stay on the ports until the next packet begins. The surrounding logic uses them to decide whether the attached device may be trusted.

Top module: `auth_resp_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `done` = 0 and `verdict` = 2'b00, and the byte position returns to 0.
- R2: The byte at offset 0 is the key. Bytes at offsets 4 to 35 are XORed with the key before use. Offsets 0, 1, 2 and 3 are used unchanged.
- R3: A packet is 37 bytes long. When the modulo-256 sum of the recovered bytes at offsets 0 to 35 equals the raw byte at offset 36, and no signature match applies, the verdict is genuine, `verdict` = 2'b01.
- R4: When that sum differs from byte 36, and no signature match applies, the verdict is illegal, `verdict` = 2'b10.
- R5: When the raw bytes at offsets 0 to 7 are 51 33 51 00 C8 9D D4 3E (hex), the verdict is counterfeit, `verdict` = 2'b11, whatever the checksum outcome.
- R6: A packet of 37 zero bytes is judged genuine.
- R7: `done` rises, with the verdict, in the cycle after byte 36 is accepted. Both hold until the first byte of the next packet is accepted, and read 0 / 2'b00 in the cycle after that.
- R8: A cycle with `in_valid` low consumes no byte and changes no state. Idle gaps inside a packet do not alter the verdict.
- R9: A synchronous reset in the middle of a packet discards the partial packet. The next accepted byte is offset 0.
- R10: `in_ready` is low in the cycle after a reset edge and high in every cycle after a non-reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Packet byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | A verdict is present and held |
| verdict | output | 2 | 00 none, 01 genuine, 10 illegal, 11 counterfeit |

## Verification
The assertions assume three things about the inputs. `in_valid` and `in_data` change only between clock edges. A packet is always a whole run of 37 accepted bytes, unless a reset cuts it off. No byte stands outside a packet boundary.

The stimulus keeps within this. It drives inputs on the falling edge, sends every packet complete, and uses reset as the only way to abandon one. It varies keys, idle gaps, signature prefixes and checksum outcomes across the packets.

// File: rtl/auth_chk_pkg.sv
// Package: shared constants and the verdict encoding for the checker.
// Assumes byte-wide transfers; verdict codes are visible at the top ports.
package auth_chk_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        VERDICT_NONE        = 2'b00,
        VERDICT_GENUINE     = 2'b01,
        VERDICT_ILLEGAL     = 2'b10,
        VERDICT_COUNTERFEIT = 2'b11
    } verdict_e;

endpackage

// File: rtl/auth_pkt_seq.sv
// Module: byte position tracker for one packet.
// Counts accepted bytes from 0 to PKT_LEN-1 and wraps; flags the first and
// the last position. Assumes PKT_LEN >= 2.
module auth_pkt_seq #(
    parameter int PKT_LEN = 37,
    localparam int POS_W  = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic [POS_W-1:0] pos,
    output logic             first,
    output logic             last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    logic [POS_W-1:0] pos_q;

    // Advance on each accepted byte, wrapping after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (take) begin
            if (pos_q == LAST_POS) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // Decode the boundary positions for the datapath.
    always_comb begin
        pos   = pos_q;
        first = (pos_q == '0);
        last  = (pos_q == LAST_POS);
    end

endmodule

// File: rtl/auth_unmask.sv
// Module: payload unmasking.
// Captures the key from the byte at position 0 and XORs it into bytes whose
// position lies in [MASK_LO, MASK_HI]; other bytes pass unchanged.
// Assumes MASK_LO > 0, so the key is always captured before it is needed.
module auth_unmask #(
    parameter int DW      = 8,
    parameter int POS_W   = 6,
    parameter int MASK_LO = 4,
    parameter int MASK_HI = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic [POS_W-1:0] pos,
    input  logic [DW-1:0]    raw,
    output logic [DW-1:0]    plain
);

    localparam logic [POS_W-1:0] LO = POS_W'(MASK_LO);
    localparam logic [POS_W-1:0] HI = POS_W'(MASK_HI);

    logic [DW-1:0] key_q;
    logic          in_window;

    // Hold the key taken from the opening byte of the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (take && first) begin
            key_q <= raw;
        end
    end

    // Apply the key only inside the masked window.
    always_comb begin
        in_window = (pos >= LO) && (pos <= HI);
        plain     = in_window ? (raw ^ key_q) : raw;
    end

endmodule

// File: rtl/auth_sum_acc.sv
// Module: running modulo-2^DW checksum.
// Restarts with the byte at position 0 and adds every recovered byte below
// SUM_END. Positions at or beyond SUM_END leave the sum untouched.
module auth_sum_acc #(
    parameter int DW      = 8,
    parameter int POS_W   = 6,
    parameter int SUM_END = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic [POS_W-1:0] pos,
    input  logic [DW-1:0]    plain,
    output logic [DW-1:0]    sum
);

    localparam logic [POS_W-1:0] END_POS = POS_W'(SUM_END);

    logic [DW-1:0] sum_q;

    // Accumulate covered bytes; the first byte seeds a fresh sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (take) begin
            if (first) begin
                sum_q <= plain;
            end else if (pos < END_POS) begin
                sum_q <= sum_q + plain;
            end
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/auth_sig_match.sv
// Module: counterfeit prefix detector.
// Compares the first SIG_LEN raw bytes with the signature held in SIG, most
// significant byte first. The flag is settled once position SIG_LEN-1 has
// been accepted. Assumes 2 <= SIG_LEN < packet length.
module auth_sig_match #(
    parameter int                    DW      = 8,
    parameter int                    POS_W   = 6,
    parameter int                    SIG_LEN = 8,
    parameter logic [SIG_LEN*DW-1:0] SIG     = 64'h5133_5100_C89D_D43E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic [POS_W-1:0] pos,
    input  logic [DW-1:0]    raw,
    output logic             match
);

    localparam int               IDX_W   = $clog2(SIG_LEN);
    localparam logic [POS_W-1:0] END_POS = POS_W'(SIG_LEN);

    logic [DW-1:0]    sig_byte [SIG_LEN];
    logic [IDX_W-1:0] idx;
    logic             in_prefix;
    logic             byte_eq;
    logic             match_q;

    // Split the signature vector into bytes, first byte at the top.
    for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
        assign sig_byte[g] = SIG[(SIG_LEN-1-g)*DW +: DW];
    end

    // Compare the current byte with its signature counterpart.
    always_comb begin
        in_prefix = (pos < END_POS);
        idx       = in_prefix ? pos[IDX_W-1:0] : '0;
        byte_eq   = (raw == sig_byte[idx]);
    end

    // Fold each prefix comparison into the running match flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else if (take) begin
            if (first) begin
                match_q <= byte_eq;
            end else if (in_prefix) begin
                match_q <= match_q & byte_eq;
            end
        end
    end

    assign match = match_q;

endmodule

// File: rtl/auth_resp_checker.sv
// Module: top of the authentication response checker.
// Accepts one byte per cycle while in_ready is high. It unmasks, sums and
// prefix-checks the bytes on the fly, and at the final byte it latches a
// verdict with done. Verdict and done are held until the next packet's first
// byte. Assumes packets are whole; a synchronous reset abandons a partial one.
module auth_resp_checker #(
    parameter int     PKT_LEN = 37,
    parameter int     MASK_LO = 4,
    parameter int     SIG_LEN = 8,
    parameter logic [SIG_LEN*auth_chk_pkg::BYTE_W-1:0] SIG = 64'h5133_5100_C89D_D43E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       done,
    output logic [1:0] verdict
);

    import auth_chk_pkg::*;

    localparam int DW      = BYTE_W;
    localparam int POS_W   = $clog2(PKT_LEN);
    localparam int SUM_END = PKT_LEN - 1;
    localparam int MASK_HI = PKT_LEN - 2;

    logic             ready_q;
    logic             take;
    logic [POS_W-1:0] byte_pos;
    logic             at_first;
    logic             at_last;
    logic [DW-1:0]    plain_byte;
    logic [DW-1:0]    run_sum;
    logic             sig_hit;
    logic             done_q;
    verdict_e         verdict_q;
    verdict_e         verdict_d;

    // Ready comes up on the first cycle after reset and stays up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign in_ready = ready_q;
    assign take     = in_valid && ready_q;

    auth_pkt_seq #(
        .PKT_LEN (PKT_LEN)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .pos   (byte_pos),
        .first (at_first),
        .last  (at_last)
    );

    auth_unmask #(
        .DW      (DW),
        .POS_W   (POS_W),
        .MASK_LO (MASK_LO),
        .MASK_HI (MASK_HI)
    ) u_unmask (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .first (at_first),
        .pos   (byte_pos),
        .raw   (in_data),
        .plain (plain_byte)
    );

    auth_sum_acc #(
        .DW      (DW),
        .POS_W   (POS_W),
        .SUM_END (SUM_END)
    ) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .first (at_first),
        .pos   (byte_pos),
        .plain (plain_byte),
        .sum   (run_sum)
    );

    auth_sig_match #(
        .DW      (DW),
        .POS_W   (POS_W),
        .SIG_LEN (SIG_LEN),
        .SIG     (SIG)
    ) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .first (at_first),
        .pos   (byte_pos),
        .raw   (in_data),
        .match (sig_hit)
    );

    // Pick the verdict: the signature outranks the checksum comparison.
    always_comb begin
        if (sig_hit) begin
            verdict_d = VERDICT_COUNTERFEIT;
        end else if (run_sum == in_data) begin
            verdict_d = VERDICT_GENUINE;
        end else begin
            verdict_d = VERDICT_ILLEGAL;
        end
    end

    // Latch the verdict at the final byte; clear it when a packet starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            verdict_q <= VERDICT_NONE;
        end else if (take) begin
            if (at_last) begin
                done_q    <= 1'b1;
                verdict_q <= verdict_d;
            end else if (at_first) begin
                done_q    <= 1'b0;
                verdict_q <= VERDICT_NONE;
            end
        end
    end

    assign done    = done_q;
    assign verdict = verdict_q;

endmodule

// File: rtl/auth_resp_checker_sva.sv
// Module: assertion checker bound to auth_resp_checker.
// Assumes inputs settle between clock edges and packets are whole.
module auth_resp_checker_sva #(
    parameter int PKT_LEN = 37,
    localparam int POS_W  = $clog2(PKT_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic [1:0]       verdict,
    input logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    // R1: a reset edge leaves a cleared result and position.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && verdict == 2'b00 && pos == '0));

    // R7: done and a real verdict always appear together.
    p_done_pairs_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done == (verdict != 2'b00));

    // R7: done rises only right after the final byte is taken.
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && pos == LAST_POS) |=> done);

    // R7: without an accepted byte, a present verdict is held.
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(in_valid && in_ready)) |=> (done && $stable(verdict)));

    // R8: idle cycles do not move the byte position.
    p_idle_no_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(pos));

    // R10: ready is up after any non-reset edge.
    p_ready_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> in_ready);

    // R3: the position never leaves the packet range.
    p_pos_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS);

endmodule

bind auth_resp_checker auth_resp_checker_sva #(
    .PKT_LEN (PKT_LEN)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .verdict  (verdict),
    .pos      (byte_pos)
);

// File: tb/auth_resp_checker_bench.sv
// Scoreboard bench: the driver pushes the modelled verdict of each packet,
// and a monitor pops it when done rises and compares.
module auth_resp_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       done;
    logic [1:0] verdict;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;
    logic [1:0] exp_q [$];
    logic [7:0] pkt [N];
    logic       prev_done = 1'b0;
    logic [7:0] sig [8] = '{8'h51, 8'h33, 8'h51, 8'h00, 8'hC8, 8'h9D, 8'hD4, 8'h3E};
    int unsigned lcg = 32'h1234_5678;

    auth_resp_checker u_auth_resp_checker (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .done     (done),
        .verdict  (verdict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) check(1'b0, "R7 pending verdicts", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic logic [7:0] next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    // Checksum of the model: keyed XOR on 4..35, plain on 0..3 (R2, R3).
    function automatic logic [7:0] model_sum();
        logic [7:0] s = 8'h00;
        for (int i = 0; i < N - 1; i++) s += (i >= 4) ? (pkt[i] ^ pkt[0]) : pkt[i];
        return s;
    endfunction

    function automatic logic [1:0] model_verdict();
        bit hit = 1'b1;
        for (int i = 0; i < 8; i++) if (pkt[i] != sig[i]) hit = 1'b0;
        if (hit) return 2'b11;
        return (model_sum() == pkt[N-1]) ? 2'b01 : 2'b10;
    endfunction

    task automatic build(input logic [7:0] key, input bit use_sig, input bit good);
        pkt[0] = key;
        for (int i = 1; i < N; i++) pkt[i] = next_rand();
        if (use_sig) for (int i = 0; i < 8; i++) pkt[i] = sig[i];
        pkt[N-1] = good ? model_sum() : model_sum() + 8'h01;
    endtask

    // Drive one packet; gap inserts idle cycles, chk_clear checks R7 clearing.
    task automatic send_pkt(input bit gap, input bit chk_clear);
        exp_q.push_back(model_verdict());
        for (int i = 0; i < N; i++) begin
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
            if (chk_clear && i == 1)
                check(!done && verdict == 2'b00, "R7 clear on next packet", {done, verdict}, 0);
            in_valid = 1'b1;
            in_data  = pkt[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each rising done with the oldest expected verdict.
    always @(negedge clk) begin
        if (rst_n && done && !prev_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", verdict, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check(verdict == e, "R2 R3 R4 R5 R6 verdict", verdict, e);
            end
        end
        prev_done = done;
    end

    // Watchdog.
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        check(1'b0, "watchdog expired", cycles, 0);
        finish_run();
    end

    initial begin
        logic [1:0] held;
        repeat (3) @(negedge clk);
        check(!done && verdict == 2'b00, "R1 reset state", {done, verdict}, 0);
        check(!in_ready, "R10 ready low in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R10 ready after reset", in_ready, 1);

        // R3 / R2: genuine packets with several keys.
        build(8'h5A, 1'b0, 1'b1); send_pkt(1'b0, 1'b0);
        build(8'hFF, 1'b0, 1'b1); send_pkt(1'b0, 1'b0);
        build(8'h00, 1'b0, 1'b1); send_pkt(1'b0, 1'b0);
        // R4: bad checksum.
        build(8'hA7, 1'b0, 1'b0); send_pkt(1'b0, 1'b0);
        build(8'h13, 1'b0, 1'b0); send_pkt(1'b0, 1'b0);
        // R5: signature with a bad and with a good checksum.
        build(8'h00, 1'b1, 1'b0); send_pkt(1'b0, 1'b0);
        build(8'h00, 1'b1, 1'b1); send_pkt(1'b0, 1'b0);
        // R5 boundary: last signature byte differs -> checksum decides.
        build(8'h00, 1'b1, 1'b1); pkt[7] = 8'h3F; pkt[N-1] = model_sum(); send_pkt(1'b0, 1'b0);
        // R6: all-zero packet.
        for (int i = 0; i < N; i++) pkt[i] = 8'h00;
        send_pkt(1'b0, 1'b0);
        // R8: idle gaps inside a packet.
        build(8'hC3, 1'b0, 1'b1); send_pkt(1'b1, 1'b0);

        // R7: hold across idle cycles, then clear on the next packet.
        build(8'h6E, 1'b0, 1'b0); send_pkt(1'b0, 1'b0);
        held = verdict;
        repeat (5) @(negedge clk);
        check(done && verdict == 2'b10 && verdict == held, "R7 held while idle", {done, verdict}, 3'b110);
        build(8'h29, 1'b0, 1'b1); send_pkt(1'b0, 1'b1);

        // R9: reset in mid-packet, then a full packet.
        build(8'h44, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pkt[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(!done && verdict == 2'b00, "R1 reset clears result", {done, verdict}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        build(8'h81, 1'b0, 1'b1); send_pkt(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(done && verdict == 2'b01, "R9 restart after reset", {done, verdict}, 3'b101);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule